// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Split Read

This block keeps a 12-bit count of elapsed microseconds. A prescaler divides the system clock down to a single-cycle enable once per microsecond, and the counter advances on each enable. It runs without stopping and wraps from 0xFFF back to zero, so it can time spans of up to 4096 µs. Two periodic interrupt requests come from carries out of the low count bits. One pulses every 128 µs and the other every 1024 µs.

Software reads the count through an 8-bit data port with two strobes. The low-byte strobe returns count bits [7:0]. In the same cycle it copies count bits [11:8] into a 4-bit holding register. The high-nibble strobe returns that held copy rather than the live count. A low read followed by a high read therefore always forms one consistent 12-bit value, however many cycles separate the two reads.

Top module: `usec_timer`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it falls, the low read and the high read both return 0 and both interrupt outputs are 0.
- R2: After N clock edges since reset, with divisor D (default 12), the low-byte read returns floor(N/D) mod 256 in bits [7:0].
- R3: The count wraps from 0xFFF to 0x000 and keeps counting, so after the wrap the low read returns floor(N/D) mod 256 and the held nibble returns (floor(N/D) div 256) mod 16.
- R4: `irq_fast` is high for exactly one cycle, the cycle after the tick that carries count bits [6:0] from 0x7F to 0x00. It is low at every other time.
- R5: `irq_slow` is high for exactly one cycle, the cycle after the tick that carries count bits [9:0] from 0x3FF to 0x000. It is low at every other time.
- R6: A low-byte read captures count bits [11:8] into the holding register. A later high-nibble read returns that value in bits [3:0], with bits [7:4] as zero.
- R7: The holding register changes only on a low-byte read. High-nibble reads and counter advances leave it unchanged.
- R8: When a low-byte read falls in the same cycle as a counter advance, both the returned low byte and the captured nibble come from the count before the advance.
- R9: With neither strobe high, `rd_data` is 0. With both strobes high, the low-byte read takes priority: it returns the low byte and captures the nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_lo_stb | input | 1 | Read strobe for count bits [7:0]; also captures bits [11:8] |
| rd_hi_stb | input | 1 | Read strobe for the held upper nibble |
| rd_data | output | 8 | Read data, valid in the same cycle as the strobe |
| irq_fast | output | 1 | One-cycle pulse every 128 µs |
| irq_slow | output | 1 | One-cycle pulse every 1024 µs |

## Verification
The assertions place no restriction on the strobes. Any mix of low, high, both or no strobe in any cycle is legal, and the properties relate the count, the holding register and the outputs to whatever strobes were sampled. The one-cycle pulse property does rely on the interrupt period being longer than one clock cycle, which holds for any divisor of at least one.

The stimulus changes the strobes only on falling clock edges and never holds them across two edges unintentionally. It places low reads at every prescaler phase, including the phase where the count advances at the nibble carry and at the 0xFFF wrap.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic fast;
        logic slow;
    } irq_pair_t;

    // Low-byte strobe wins when both strobes are raised together.
    function automatic rd_sel_e decode_sel(input logic lo, input logic hi);
        rd_sel_e s;
        if (lo)      s = SEL_LO;
        else if (hi) s = SEL_HI;
        else         s = SEL_IDLE;
        return s;
    endfunction

endpackage

// File: rtl/utmr_prescaler.sv
module utmr_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            logic          at_end;

            assign at_end = (pre_q == PW'(DIV - 1));
            assign tick   = at_end;

            always_ff @(posedge clk) begin
                if (rst)         pre_q <= '0;
                else if (at_end) pre_q <= '0;
                else             pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/utmr_carry_pulse.sv
module utmr_carry_pulse #(
    parameter int LOG = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [LOG-1:0] low_bits,
    output logic           pulse
);
    logic pulse_q;

    // The advance that rolls the low field over is registered, so the pulse
    // lines up with the cycle in which the low field reads zero.
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= tick && (&low_bits);
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/utmr_snapshot.sv
module utmr_snapshot #(
    parameter int HI_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [HI_W-1:0] upper,
    output logic [HI_W-1:0] held
);
    logic [HI_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)          held_q <= '0;
        else if (capture) held_q <= upper;
    end

    assign held = held_q;
endmodule

// File: rtl/utmr_readmux.sv
module utmr_readmux
    import usec_timer_pkg::*;
#(
    parameter int RD_W = 8,
    parameter int HI_W = 4
) (
    input  rd_sel_e         sel,
    input  logic [RD_W-1:0] low_byte,
    input  logic [HI_W-1:0] held,
    output logic [RD_W-1:0] rd_data
);
    logic [RD_W-1:0] hi_word;

    generate
        if (HI_W < RD_W) begin : g_pad
            assign hi_word = {{(RD_W - HI_W){1'b0}}, held};
        end else begin : g_trim
            assign hi_word = held[RD_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_LO:  rd_data = low_byte;
            SEL_HI:  rd_data = hi_word;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int CLK_PER_US = 12,
    parameter int CNT_W      = 12,
    parameter int RD_W       = 8,
    parameter int FAST_LOG   = 7,
    parameter int SLOW_LOG   = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_lo_stb,
    input  logic            rd_hi_stb,
    output logic [RD_W-1:0] rd_data,
    output logic            irq_fast,
    output logic            irq_slow
);
    localparam int HI_W = CNT_W - RD_W;

    logic             us_tick;
    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  hold_q;
    rd_sel_e          sel;
    irq_pair_t        irq;

    assign sel = decode_sel(rd_lo_stb, rd_hi_stb);

    utmr_prescaler #(.DIV(CLK_PER_US)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick)
    );

    utmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick),
        .cnt  (cnt_q)
    );

    utmr_carry_pulse #(.LOG(FAST_LOG)) u_fast (
        .clk      (clk),
        .rst      (rst),
        .tick     (us_tick),
        .low_bits (cnt_q[FAST_LOG-1:0]),
        .pulse    (irq.fast)
    );

    utmr_carry_pulse #(.LOG(SLOW_LOG)) u_slow (
        .clk      (clk),
        .rst      (rst),
        .tick     (us_tick),
        .low_bits (cnt_q[SLOW_LOG-1:0]),
        .pulse    (irq.slow)
    );

    utmr_snapshot #(.HI_W(HI_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (sel == SEL_LO),
        .upper   (cnt_q[CNT_W-1:RD_W]),
        .held    (hold_q)
    );

    utmr_readmux #(.RD_W(RD_W), .HI_W(HI_W)) u_mux (
        .sel      (sel),
        .low_byte (cnt_q[RD_W-1:0]),
        .held     (hold_q),
        .rd_data  (rd_data)
    );

    assign irq_fast = irq.fast;
    assign irq_slow = irq.slow;
endmodule

// File: rtl/usec_timer_checker.sv
module usec_timer_checker #(
    parameter int CNT_W    = 12,
    parameter int RD_W     = 8,
    parameter int FAST_LOG = 7,
    parameter int SLOW_LOG = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_lo_stb,
    input logic                 rd_hi_stb,
    input logic [RD_W-1:0]      rd_data,
    input logic                 irq_fast,
    input logic                 irq_slow,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-RD_W-1:0] hold
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));  // R3

    AST_FAST_ALIGN: assert property (@(posedge clk) disable iff (rst)
        irq_fast |-> (cnt[FAST_LOG-1:0] == '0));  // R4

    AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_fast |=> !irq_fast);  // R4

    AST_SLOW_ALIGN: assert property (@(posedge clk) disable iff (rst)
        irq_slow |-> (irq_fast && cnt[SLOW_LOG-1:0] == '0));  // R5

    AST_CAPTURE_PRE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_lo_stb)) |-> (hold == $past(cnt[CNT_W-1:RD_W])));  // R8

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rd_lo_stb)) |-> $stable(hold));  // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rd_lo_stb && !rd_hi_stb) |-> (rd_data == '0));  // R9
endmodule

bind usec_timer usec_timer_checker #(
    .CNT_W    (CNT_W),
    .RD_W     (RD_W),
    .FAST_LOG (FAST_LOG),
    .SLOW_LOG (SLOW_LOG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_lo_stb (rd_lo_stb),
    .rd_hi_stb (rd_hi_stb),
    .rd_data   (rd_data),
    .irq_fast  (irq_fast),
    .irq_slow  (irq_slow),
    .cnt       (cnt_q),
    .hold      (hold_q)
);

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_lo_stb = 1'b0;
    logic       rd_hi_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq_fast;
    logic       irq_slow;

    int n = 0;
    int checks = 0;
    int errs = 0;
    int exp_hold = 0;

    always #10 clk = ~clk;

    usec_timer u_usec_timer (
        .clk       (clk),
        .rst       (rst),
        .rd_lo_stb (rd_lo_stb),
        .rd_hi_stb (rd_hi_stb),
        .rd_data   (rd_data),
        .irq_fast  (irq_fast),
        .irq_slow  (irq_slow)
    );

    // Edges counted since reset was released.
    always @(posedge clk) n <= rst ? 0 : n + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (edges=%0d)", req, act, exp_v, n);
        end
    endtask

    // Interrupt pulse monitor, evaluated well after the falling edge.
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            int t;
            t = n / DIV;
            check("R4", {31'd0, irq_fast}, {31'd0, n > 0 && n % DIV == 0 && t % 128 == 0});
            check("R5", {31'd0, irq_slow}, {31'd0, n > 0 && n % DIV == 0 && t % 1024 == 0});
        end
    end

    task automatic lo_read(input string req);
        int t;
        @(negedge clk);
        rd_hi_stb = 1'b0;
        rd_lo_stb = 1'b1;
        t = n / DIV;
        #1 check(req, rd_data, t % 256);
        exp_hold = (t / 256) % 16;
    endtask

    task automatic hi_read(input string req);
        @(negedge clk);
        rd_lo_stb = 1'b0;
        rd_hi_stb = 1'b1;
        #1 check(req, rd_data, exp_hold);
    endtask

    task automatic sweep(input int stop_edges);
        int c = 0;
        while (n < stop_edges) begin
            int cur;
            int t;
            bit force_rd;
            @(negedge clk);
            rd_lo_stb = 1'b0;
            rd_hi_stb = 1'b0;
            cur = n;
            t = cur / DIV;
            force_rd = (t % 256 == 255 && cur % DIV == DIV - 1) || (cur == 4096 * DIV);
            if (c % 37 == 0 || force_rd) begin
                string req;
                rd_lo_stb = 1'b1;
                if (cur % DIV == DIV - 1) req = "R8";
                else if (t >= 4096)       req = "R3";
                else                      req = "R2";
                #1 check(req, rd_data, t % 256);
                exp_hold = (t / 256) % 16;
            end else if (c % 37 == 11) begin
                rd_hi_stb = 1'b1;
                #1 check("R6", rd_data, exp_hold);
            end else if (c % 37 == 23) begin
                rd_hi_stb = 1'b1;
                #1 check("R7", rd_data, exp_hold);
            end else if (c % 37 == 30) begin
                rd_lo_stb = 1'b1;
                rd_hi_stb = 1'b1;
                #1 check("R9", rd_data, t % 256);
                exp_hold = (t / 256) % 16;
            end else begin
                #1 check("R9", rd_data, 0);
            end
            c++;
        end
        @(negedge clk);
        rd_lo_stb = 1'b0;
        rd_hi_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd_hi_stb = 1'b1;
        #1 check("R1", rd_data, 0);
        check("R1", {30'd0, irq_fast, irq_slow}, 0);
        rd_hi_stb = 1'b0;
        rst = 1'b0;
        lo_read("R1");
        hi_read("R1");

        // First run, stopped with a non-zero upper nibble held.
        sweep(16'h5A0 * DIV + 5);
        lo_read("R2");
        hi_read("R6");
        hi_read("R7");

        // Mid-run reset clears the held nibble and the count.
        @(negedge clk);
        rd_hi_stb = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rd_hi_stb = 1'b1;
        #1 check("R1", rd_data, 0);
        rd_hi_stb = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        rd_hi_stb = 1'b1;
        #1 check("R1", rd_data, 0);
        lo_read("R1");

        // Full run through the 0xFFF wrap.
        sweep(4096 * DIV + 700);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule